// File: doc/BRIEF.md
# Data-Processing Result and Status-Flag Writeback

This unit sits behind the ALU of a 32-bit load/store processor core. Each cycle it is given the decoded data-processing opcode, the set-flags bit, the destination register index, both operands, the ALU result, the ALU carry-out, the shifter carry-out and the incoming carry flag. From these it forms a register-file write request and the next values of the four condition flags. It then commits those flags into a 32-bit current status word on the clock edge at which the instruction strobe is high.

A write to the program counter (register 15) is a special case. The unit raises a pipeline reload request in the same cycle as the write. If the set-flags bit is also high, the whole status word is replaced by the saved status word supplied on its input, and the usual flag update is skipped. Compare/test opcodes (0x8 to 0xB) only touch the flags. They never write a register and never cause a reload, even when their destination field is 15.

The register-write side is combinational and has no back-pressure. The register file must take the write in the cycle that `wb_we` is high. All control pins are plain levels.

Top module: `dp_writeback`

## Requirements
- R1: Reset (active-low `rst_n`) sets `status` to the parameter `RESET_SR` (default 0x000000D3).
- R2: Opcodes 0x8 to 0xB never raise `wb_we` or `reload_req`, whatever the destination index is, including 15.
- R3: With `instr_vld` high and a non-test opcode, `wb_we` is high in the same cycle, `wb_addr` equals `rd_idx` and `wb_data` equals `alu_res`. With `instr_vld` low, `wb_we` and `reload_req` are low.
- R4: Flag layout is N=bit 31, Z=bit 30, C=bit 29, V=bit 28. For logical opcodes (0x0, 0x1, 0x8, 0x9, 0xC to 0xF) with S set, N is result bit 31, Z is set when the result is zero, C is `shf_cout`, and V keeps its old value.
- R5: For addition opcodes (0x4 ADD, 0x5 ADC, 0xB compare-negative) with S set, C is `alu_cout` and V is bit 31 of (op_a^res)&(op_b^res).
- R6: For subtraction opcodes with S set, C is set when the minuend is at least the subtrahend (no borrow), and V is bit 31 of (min^sub)&(min^res). The minuend is `op_a` for 0x2 and 0xA and `op_b` for 0x3 (reverse). `alu_cout` is ignored for these opcodes.
- R7: For the carry-subtract opcodes 0x6 (minuend `op_a`) and 0x7 (reverse, minuend `op_b`), C is set when the minuend is at least the subtrahend plus the inverse of `carry_in`, compared at 33 bits. V follows R6.
- R8: `reload_req` is high in exactly the cycles where `instr_vld` is high, the opcode is not a test, and `rd_idx` is 15.
- R9: A valid non-test opcode with S set and `rd_idx` 15 loads all 32 bits of `saved_sr` into `status` at the edge, and no flag computation is applied.
- R10: When S is clear or `instr_vld` is low, `status` does not change. A flag update never alters `status` bits 27:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_vld | input | 1 | Instruction strobe; commits this cycle's update |
| opcode | input | 4 | Data-processing opcode |
| set_flags | input | 1 | S bit |
| rd_idx | input | 4 | Destination register index |
| op_a | input | 32 | First operand (register operand) |
| op_b | input | 32 | Second operand (shifter output) |
| alu_res | input | 32 | ALU result |
| alu_cout | input | 1 | Unsigned carry-out of the ALU adder |
| shf_cout | input | 1 | Barrel-shifter carry-out |
| carry_in | input | 1 | Current C flag used by carry-subtract |
| saved_sr | input | 32 | Saved status word for restore |
| wb_we | output | 1 | Register-file write enable |
| wb_addr | output | 4 | Register-file write index |
| wb_data | output | 32 | Register-file write data |
| reload_req | output | 1 | Pipeline reload request |
| status | output | 32 | Current status word |

## Verification
The assertions assume that every input has a known value in each cycle after reset. They also assume that `carry_in` matches the C flag the core actually holds. Flags are computed from the operands, not cross-checked against `alu_res`, so the directed stimulus always supplies a result that is consistent with its operands and opcode. Inputs change only at the falling edge. The flag vectors were worked out by hand: borrow and no-borrow pairs, signed overflow, equal operands with carry-in clear, and an all-ones subtrahend that needs the 33rd bit.

// File: rtl/dp_writeback_pkg.sv
package dp_writeback_pkg;

  typedef enum logic [1:0] {
    FC_LOGIC = 2'd0,
    FC_ADD   = 2'd1,
    FC_SUB   = 2'd2,
    FC_SBC   = 2'd3
  } flag_class_e;

  function automatic flag_class_e classify(input logic [3:0] op);
    case (op)
      4'h2, 4'h3, 4'hA: classify = FC_SUB;
      4'h4, 4'h5, 4'hB: classify = FC_ADD;
      4'h6, 4'h7:       classify = FC_SBC;
      default:          classify = FC_LOGIC;
    endcase
  endfunction

  function automatic logic is_test(input logic [3:0] op);
    is_test = (op[3:2] == 2'b10);
  endfunction

  function automatic logic is_reversed(input logic [3:0] op);
    is_reversed = (op == 4'h3) || (op == 4'h7);
  endfunction

endpackage

// File: rtl/dp_flag_calc.sv
module dp_flag_calc
  import dp_writeback_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [3:0]      opcode,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [XLEN-1:0] alu_res,
  input  logic            alu_cout,
  input  logic            shf_cout,
  input  logic            carry_in,
  input  logic            v_old,
  output logic [3:0]      nzcv
);
  localparam int MSB = XLEN - 1;

  flag_class_e     cls;
  logic [XLEN-1:0] minuend, subtrahend;
  logic [XLEN:0]   sub_ext;
  logic            c_sub, v_sub, v_add, n_f, z_f;

  always_comb begin
    cls        = classify(opcode);
    minuend    = is_reversed(opcode) ? op_b : op_a;
    subtrahend = is_reversed(opcode) ? op_a : op_b;
    sub_ext    = {1'b0, subtrahend};
    if (cls == FC_SBC) sub_ext = sub_ext + {{XLEN{1'b0}}, ~carry_in};
    c_sub = ({1'b0, minuend} >= sub_ext);
    v_sub = ((minuend ^ subtrahend) & (minuend ^ alu_res)) >> MSB != '0;
    v_add = ((op_a ^ alu_res) & (op_b ^ alu_res)) >> MSB != '0;
    n_f   = alu_res[MSB];
    z_f   = (alu_res == '0);
    case (cls)
      FC_ADD:  nzcv = {n_f, z_f, alu_cout, v_add};
      FC_SUB,
      FC_SBC:  nzcv = {n_f, z_f, c_sub, v_sub};
      default: nzcv = {n_f, z_f, shf_cout, v_old};
    endcase
  end

endmodule

// File: rtl/dp_wb_ctrl.sv
module dp_wb_ctrl
  import dp_writeback_pkg::*;
#(
  parameter int RIDX_W = 4,
  parameter int PC_IDX = 15
) (
  input  logic              instr_vld,
  input  logic [3:0]        opcode,
  input  logic              set_flags,
  input  logic [RIDX_W-1:0] rd_idx,
  output logic              wr_en,
  output logic              reload,
  output logic              restore,
  output logic              flag_upd
);
  logic test_op, hits_pc;

  always_comb begin
    test_op  = is_test(opcode);
    hits_pc  = (rd_idx == RIDX_W'(PC_IDX));
    wr_en    = instr_vld && !test_op;
    reload   = wr_en && hits_pc;
    restore  = reload && set_flags;
    flag_upd = instr_vld && set_flags && !(hits_pc && !test_op);
  end

endmodule

// File: rtl/dp_status_reg.sv
module dp_status_reg #(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_SR = 32'h0000_00D3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restore,
  input  logic            flag_upd,
  input  logic [XLEN-1:0] saved_sr,
  input  logic [3:0]      nzcv,
  output logic [XLEN-1:0] status
);
  localparam int LOW_W = XLEN - 4;

  always_ff @(posedge clk) begin
    if (!rst_n)        status <= XLEN'(RESET_SR);
    else if (restore)  status <= saved_sr;
    else if (flag_upd) status <= {nzcv, status[LOW_W-1:0]};
  end

  // R9: restore copies the saved word whole
  a_r9_restore_full: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> status == $past(saved_sr));

  // R10: no request, no change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore && !flag_upd) |=> $stable(status));

  // R10: flag update leaves low bits alone
  a_r10_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore && flag_upd) |=> status[LOW_W-1:0] == $past(status[LOW_W-1:0]));

endmodule

// File: rtl/dp_writeback.sv
module dp_writeback
  import dp_writeback_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          RIDX_W   = 4,
  parameter int          PC_IDX   = 15,
  parameter logic [31:0] RESET_SR = 32'h0000_00D3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_vld,
  input  logic [3:0]        opcode,
  input  logic              set_flags,
  input  logic [RIDX_W-1:0] rd_idx,
  input  logic [XLEN-1:0]   op_a,
  input  logic [XLEN-1:0]   op_b,
  input  logic [XLEN-1:0]   alu_res,
  input  logic              alu_cout,
  input  logic              shf_cout,
  input  logic              carry_in,
  input  logic [XLEN-1:0]   saved_sr,
  output logic              wb_we,
  output logic [RIDX_W-1:0] wb_addr,
  output logic [XLEN-1:0]   wb_data,
  output logic              reload_req,
  output logic [XLEN-1:0]   status
);
  localparam int V_BIT = XLEN - 4;

  logic       restore, flag_upd;
  logic [3:0] nzcv;

  dp_wb_ctrl #(.RIDX_W(RIDX_W), .PC_IDX(PC_IDX)) u_ctrl (
    .instr_vld (instr_vld),
    .opcode    (opcode),
    .set_flags (set_flags),
    .rd_idx    (rd_idx),
    .wr_en     (wb_we),
    .reload    (reload_req),
    .restore   (restore),
    .flag_upd  (flag_upd)
  );

  dp_flag_calc #(.XLEN(XLEN)) u_flags (
    .opcode   (opcode),
    .op_a     (op_a),
    .op_b     (op_b),
    .alu_res  (alu_res),
    .alu_cout (alu_cout),
    .shf_cout (shf_cout),
    .carry_in (carry_in),
    .v_old    (status[V_BIT]),
    .nzcv     (nzcv)
  );

  dp_status_reg #(.XLEN(XLEN), .RESET_SR(RESET_SR)) u_sr (
    .clk      (clk),
    .rst_n    (rst_n),
    .restore  (restore),
    .flag_upd (flag_upd),
    .saved_sr (saved_sr),
    .nzcv     (nzcv),
    .status   (status)
  );

  assign wb_addr = rd_idx;
  assign wb_data = alu_res;

  // R2: compare/test never writes or reloads
  a_r2_test_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    is_test(opcode) |-> (!wb_we && !reload_req));

  // R8: reload only alongside a write to the PC index
  a_r8_reload_pc: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |-> (wb_we && wb_addr == RIDX_W'(PC_IDX)));

  // R3: idle strobe means no write
  a_r3_idle_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_vld |-> (!wb_we && !reload_req));

  // R4: logical opcodes keep V
  a_r4_logic_keeps_v: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_vld && set_flags && classify(opcode) == FC_LOGIC && !reload_req)
      |=> status[V_BIT] == $past(status[V_BIT]));

  // R10: S clear leaves status unchanged
  a_r10_no_s_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags |=> $stable(status));

endmodule

// File: tb/dp_writeback_bench.sv
module dp_writeback_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_vld, set_flags, alu_cout, shf_cout, carry_in;
  logic [3:0]  opcode, rd_idx;
  logic [31:0] op_a, op_b, alu_res, saved_sr;
  logic        wb_we, reload_req;
  logic [3:0]  wb_addr;
  logic [31:0] wb_data, status;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] exp_sr;

  always #5 clk = ~clk;

  dp_writeback u_dp_writeback (
    .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .opcode(opcode),
    .set_flags(set_flags), .rd_idx(rd_idx), .op_a(op_a), .op_b(op_b),
    .alu_res(alu_res), .alu_cout(alu_cout), .shf_cout(shf_cout),
    .carry_in(carry_in), .saved_sr(saved_sr), .wb_we(wb_we),
    .wb_addr(wb_addr), .wb_data(wb_data), .reload_req(reload_req),
    .status(status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one instruction at the falling edge, check combinational outputs,
  // then check status after the next rising edge.
  task automatic run_op(input string req, input logic vld, input logic [3:0] op,
                        input logic s, input logic [3:0] rd,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] res, input logic ac, input logic sc,
                        input logic ci, input logic [31:0] new_sr);
    logic exp_we, exp_rl;
    instr_vld = vld; opcode = op; set_flags = s; rd_idx = rd;
    op_a = a; op_b = b; alu_res = res; alu_cout = ac; shf_cout = sc; carry_in = ci;
    exp_we = vld && (op[3:2] != 2'b10);
    exp_rl = exp_we && (rd == 4'hF);
    #1;
    check({req, " we"}, {31'b0, wb_we}, {31'b0, exp_we});
    check({req, " reload"}, {31'b0, reload_req}, {31'b0, exp_rl});
    if (exp_we) begin
      check({req, " addr"}, {28'b0, wb_addr}, {28'b0, rd});
      check({req, " data"}, wb_data, res);
    end
    @(negedge clk);
    instr_vld = 1'b0;
    exp_sr = new_sr;
    check({req, " status"}, status, exp_sr);
  endtask

  task automatic t_reset;   // R1
    check("R1 reset status", status, 32'h0000_00D3);
    check("R1 reset we", {31'b0, wb_we}, 32'd0);
  endtask

  task automatic t_logic;   // R4, R3
    run_op("R4 and neg", 1, 4'h0, 1, 4'h3, 32'hF000_0000, 32'h8000_0001,
           32'h8000_0000, 0, 1, 0, 32'hA000_00D3);
    run_op("R4 mov zero", 1, 4'hD, 1, 4'h1, 0, 0, 0, 1, 0, 0, 32'h4000_00D3);
  endtask

  task automatic t_add;     // R5, then R4 keeps V
    run_op("R5 add ovf", 1, 4'h4, 1, 4'h2, 32'h7FFF_FFFF, 1, 32'h8000_0000,
           0, 0, 0, 32'h9000_00D3);
    run_op("R4 eor keeps V", 1, 4'h1, 1, 4'h2, 1, 0, 1, 0, 1, 0, 32'h3000_00D3);
    run_op("R5 cmn carry", 1, 4'hB, 1, 4'h0, 32'hFFFF_FFFF, 1, 0, 1, 0, 0,
           32'h6000_00D3);
  endtask

  task automatic t_sub;     // R6
    run_op("R6 sub equal", 1, 4'h2, 1, 4'h4, 5, 5, 0, 0, 0, 0, 32'h6000_00D3);
    run_op("R6 sub borrow", 1, 4'h2, 1, 4'h4, 3, 5, 32'hFFFF_FFFE, 1, 0, 0,
           32'h8000_00D3);
    run_op("R6 rsb", 1, 4'h3, 1, 4'h4, 3, 5, 2, 0, 0, 0, 32'h2000_00D3);
    run_op("R6 sub ovf", 1, 4'h2, 1, 4'h4, 32'h8000_0000, 1, 32'h7FFF_FFFF,
           0, 0, 0, 32'h3000_00D3);
  endtask

  task automatic t_sbc;     // R7
    run_op("R7 sbc cin0", 1, 4'h6, 1, 4'h5, 5, 5, 32'hFFFF_FFFF, 0, 0, 0,
           32'h8000_00D3);
    run_op("R7 sbc cin1", 1, 4'h6, 1, 4'h5, 5, 5, 0, 0, 0, 1, 32'h6000_00D3);
    run_op("R7 rsc cin0", 1, 4'h7, 1, 4'h5, 5, 5, 32'hFFFF_FFFF, 0, 0, 0,
           32'h8000_00D3);
    run_op("R7 sbc 33bit", 1, 4'h6, 1, 4'h5, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
           32'hFFFF_FFFF, 0, 0, 0, 32'h8000_00D3);
  endtask

  task automatic t_test_pc; // R2
    run_op("R2 cmp rd15", 1, 4'hA, 1, 4'hF, 7, 2, 5, 0, 0, 0, 32'h2000_00D3);
    run_op("R2 tst rd15", 1, 4'h8, 1, 4'hF, 0, 0, 0, 0, 1, 0, 32'h6000_00D3);
  endtask

  task automatic t_quiet;   // R10, R3
    run_op("R10 s clear", 1, 4'h4, 0, 4'h2, 0, 0, 0, 1, 0, 0, exp_sr);
    run_op("R3 vld low", 0, 4'h4, 1, 4'h2, 0, 0, 0, 1, 1, 0, exp_sr);
    run_op("R8 pc no s", 1, 4'hD, 0, 4'hF, 0, 32'h100, 32'h100, 0, 1, 0, exp_sr);
  endtask

  task automatic t_restore; // R9, R8, R10
    saved_sr = 32'h1234_5678;
    run_op("R9 sub pc restore", 1, 4'h2, 1, 4'hF, 5, 5, 0, 0, 0, 0,
           32'h1234_5678);
    saved_sr = 32'hFFFF_FFFF;
    run_op("R10 low bits kept", 1, 4'h0, 1, 4'h6, 0, 0, 32'h8000_0000, 0, 0, 0,
           32'h9234_5678);
  endtask

  initial begin
    #100000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; instr_vld = 0; opcode = 0; set_flags = 0; rd_idx = 0;
    op_a = 0; op_b = 0; alu_res = 0; alu_cout = 0; shf_cout = 0; carry_in = 0;
    saved_sr = 0; exp_sr = 32'h0000_00D3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_logic();
    t_add();
    t_sub();
    t_sbc();
    t_test_pc();
    t_quiet();
    t_restore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule